// File: doc/BRIEF.md
# Keyboard Command Responder

This block sits behind the receive side of a serial keyboard link. The host sends single command bytes, and the block answers some of them by loading a short response into an outgoing byte queue. A transmitter, which is not part of this block, drains that queue through a valid/ready handshake. Three kinds of command are recognised: a reset that answers with an identification sequence, a layout query that answers with a marker and a layout code, and an LED command. The LED command takes the byte that follows it as data and does not decode that byte as a command.

A command byte is taken only when the link's transmit path is enabled and the keyboard channel is not disabled. A response always replaces whatever the queue still holds, so the host never reads the tail of an older answer ahead of a new one. The layout code is set by a parameter.

Top module: `kbd_cmd_responder`

## Requirements
- R1: After reset the response queue is empty (`rsp_valid` low) and the block is not waiting for an LED data byte.
- R2: An accepted byte 0x01 discards the queue contents and leaves exactly 0xFF, 0x04, 0x7F queued, delivered in that order.
- R3: An accepted byte 0x0E produces no response and leaves the queue as it was. It arms LED data mode.
- R4: In LED data mode, the next accepted byte is consumed as data whatever its value. It produces no response, leaves the queue as it was, and ends LED data mode, so the byte after it is decoded as a command again.
- R5: An accepted byte 0x07 or 0x0F discards the queue contents and leaves exactly 0xFE followed by the layout parameter (default 0x00) queued.
- R6: A byte offered while `tx_enable` is low or `chan_disable` is high is not accepted. It changes neither the queue nor the LED data mode.
- R7: An accepted byte with any other value outside LED data mode is ignored: no response and no change to the queue.
- R8: `rsp_valid` is high exactly while the queue holds bytes. One byte leaves on each cycle in which `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low and no command is accepted, `rsp_valid` and `rsp_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_enable | input | 1 | Link transmit path enabled; commands are taken only while high |
| chan_disable | input | 1 | Keyboard channel disabled; commands are refused while high |
| cmd_valid | input | 1 | A command byte is offered this cycle |
| cmd_byte | input | 8 | Command byte from the host |
| rsp_valid | output | 1 | Queue holds a response byte |
| rsp_data | output | 8 | Response byte at the head of the queue |
| rsp_ready | input | 1 | Consumer takes the head byte this cycle |

## Verification
A wrong LED-mode bit shows up as a missing or an unexpected response. A stuck-armed bit swallows the command that follows. A bit that never arms lets a reset code sent as LED data produce a response in the cycle right after it is accepted. A wrong queue pointer or count shows up as a byte missing from a sequence, a byte out of order, or a stale byte left over after a response should have replaced the queue. Each of these is visible on the first drain that follows. The stimulus therefore puts known-code values in the LED data slot, sends commands on top of undrained and partly drained responses, and offers bytes while the gate is closed.

// File: rtl/kbd_resp_pkg.sv
// Package: shared command codes, response bytes and sizes for the keyboard
// command responder. Assumes 8-bit host commands.
package kbd_resp_pkg;
    localparam int BYTE_W  = 8;
    localparam int MAX_RSP = 3;                    // longest response sequence
    localparam int LEN_W   = $clog2(MAX_RSP + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OP_RESET    = 8'h01;
    localparam byte_t OP_LED      = 8'h0E;
    localparam byte_t OP_LAYOUT_A = 8'h07;
    localparam byte_t OP_LAYOUT_B = 8'h0F;

    localparam byte_t ID_HEAD   = 8'hFF;
    localparam byte_t ID_TYPE   = 8'h04;
    localparam byte_t ID_TAIL   = 8'h7F;
    localparam byte_t LAYOUT_MK = 8'hFE;
endpackage

// File: rtl/kbd_cmd_decode.sv
// Module: decodes accepted command bytes into a queue load request and keeps
// the single bit that marks a pending LED data byte.
// Assumes: accept is already gated by enable/disable; at most one byte per cycle.
module kbd_cmd_decode
    import kbd_resp_pkg::*;
#(
    parameter byte_t LAYOUT = 8'h00
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  byte_t                         cmd,
    output logic                          load,
    output logic [LEN_W-1:0]              load_len,
    output logic [MAX_RSP-1:0][BYTE_W-1:0] load_bytes
);
    logic led_pending;

    // Purpose: build the response for the current byte (combinational decode).
    always_comb begin
        load       = 1'b0;
        load_len   = '0;
        load_bytes = '0;
        if (accept && !led_pending) begin
            if (cmd == OP_RESET) begin
                load          = 1'b1;
                load_len      = LEN_W'(3);
                load_bytes[0] = ID_HEAD;
                load_bytes[1] = ID_TYPE;
                load_bytes[2] = ID_TAIL;
            end else if (cmd == OP_LAYOUT_A || cmd == OP_LAYOUT_B) begin
                load          = 1'b1;
                load_len      = LEN_W'(2);
                load_bytes[0] = LAYOUT_MK;
                load_bytes[1] = LAYOUT;
            end
        end
    end

    // Purpose: arm on the LED command, disarm on the data byte that follows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_pending <= 1'b0;
        end else if (accept) begin
            led_pending <= led_pending ? 1'b0 : (cmd == OP_LED);
        end
    end

    assert_led_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !led_pending && cmd == OP_LED) |=> led_pending);
    assert_led_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && led_pending) |=> !led_pending);
    assert_led_swallow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        led_pending |-> !load);
    assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (led_pending == $past(led_pending)));
endmodule

// File: rtl/kbd_rsp_queue.sv
// Module: response byte queue. A load replaces the whole content with a new
// sequence of up to MAX_RSP bytes; the head is popped over valid/ready.
// Assumes: DEPTH >= MAX_RSP, so a load never overflows. A load outranks a pop
// in the same cycle.
module kbd_rsp_queue
    import kbd_resp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [LEN_W-1:0]               load_len,
    input  logic [MAX_RSP-1:0][BYTE_W-1:0] load_bytes,
    output logic                           out_valid,
    output byte_t                          out_data,
    input  logic                           out_ready
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    byte_t             mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              pop;

    assign pop       = out_valid && out_ready && !load;
    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];

    // Purpose: write a freshly loaded sequence from slot zero onward.
    always_ff @(posedge clk) begin
        if (load) begin
            for (int k = 0; k < MAX_RSP; k++) begin
                if (LEN_W'(k) < load_len) begin
                    mem[k] <= load_bytes[k];
                end
            end
        end
    end

    // Purpose: track head pointer and fill level across loads and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            count  <= '0;
        end else if (load) begin
            rd_ptr <= '0;
            count  <= CNT_W'(load_len);
        end else if (pop) begin
            rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count  <= count - 1'b1;
        end
    end

    initial begin
        assert_depth_fits_R2: assert (DEPTH >= MAX_RSP);
    end
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_load_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == CNT_W'($past(load_len))));
    assert_pop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !load) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/kbd_cmd_responder.sv
// Module: top of the keyboard command responder. Gates incoming bytes with the
// link enable and channel disable, decodes them and queues the responses.
// Assumes: cmd_valid is a one-cycle strobe per byte; no backpressure on input.
module kbd_cmd_responder
    import kbd_resp_pkg::*;
#(
    parameter int    DEPTH  = 16,
    parameter byte_t LAYOUT = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_enable,
    input  logic       chan_disable,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output logic       rsp_valid,
    output logic [7:0] rsp_data,
    input  logic       rsp_ready
);
    logic                           accept;
    logic                           load;
    logic [LEN_W-1:0]               load_len;
    logic [MAX_RSP-1:0][BYTE_W-1:0] load_bytes;

    // Purpose: take a byte only on an enabled, non-disabled channel.
    assign accept = cmd_valid && tx_enable && !chan_disable;

    kbd_cmd_decode #(.LAYOUT(LAYOUT)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .cmd        (cmd_byte),
        .load       (load),
        .load_len   (load_len),
        .load_bytes (load_bytes)
    );

    kbd_rsp_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_len   (load_len),
        .load_bytes (load_bytes),
        .out_valid  (rsp_valid),
        .out_data   (rsp_data),
        .out_ready  (rsp_ready)
    );

    assert_blocked_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (!tx_enable || chan_disable)) |-> !load);
    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready && !load) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/kbd_cmd_responder_bench.sv
module kbd_cmd_responder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_enable = 1'b0;
    logic       chan_disable = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       rsp_ready = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    kbd_cmd_responder u_kbd_cmd_responder (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .chan_disable(chan_disable),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready)
    );

    // en, dis, cmd, drain, n, b0, b1, b2, requirement number
    typedef struct packed {
        logic       en;
        logic       dis;
        logic [7:0] cmd;
        logic       drain;
        logic [1:0] n;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'h01, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 4'd2}, // R2 load id
        '{1'b1, 1'b0, 8'h55, 1'b1, 2'd3, 8'hFF, 8'h04, 8'h7F, 4'd7}, // R7 unknown keeps queue
        '{1'b1, 1'b0, 8'h07, 1'b1, 2'd2, 8'hFE, 8'h00, 8'h00, 4'd5}, // R5 query 0x07
        '{1'b1, 1'b0, 8'h0F, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 4'd5}, // R5 query 0x0F
        '{1'b1, 1'b0, 8'h0E, 1'b1, 2'd2, 8'hFE, 8'h00, 8'h00, 4'd3}, // R3 LED keeps queue
        '{1'b1, 1'b0, 8'h01, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 4'd4}, // R4 0x01 as LED data
        '{1'b1, 1'b0, 8'h01, 1'b1, 2'd3, 8'hFF, 8'h04, 8'h7F, 4'd4}, // R4 mode left
        '{1'b0, 1'b0, 8'h07, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 4'd6}, // R6 tx off
        '{1'b1, 1'b1, 8'h01, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 4'd6}, // R6 channel off
        '{1'b1, 1'b0, 8'h0E, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 4'd3}, // R3 no response
        '{1'b0, 1'b0, 8'h0E, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 4'd6}, // R6 blocked keeps LED mode
        '{1'b1, 1'b0, 8'h07, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 4'd4}, // R4 query as LED data
        '{1'b1, 1'b0, 8'h0F, 1'b1, 2'd2, 8'hFE, 8'h00, 8'h00, 4'd5}, // R5 query 0x0F
        '{1'b1, 1'b0, 8'h01, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 4'd2}, // R2 load id
        '{1'b1, 1'b0, 8'h07, 1'b1, 2'd2, 8'hFE, 8'h00, 8'h00, 4'd5}  // R5 flushes id
    };

    task automatic check(input bit ok, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", what, act, exp);
        end
    endtask

    task automatic send(input logic en, input logic dis, input logic [7:0] b);
        @(negedge clk);
        tx_enable = en; chan_disable = dis; cmd_valid = 1'b1; cmd_byte = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string tag);
        check(rsp_valid === 1'b1, {tag, " valid"}, {7'd0, rsp_valid}, 8'h01);
        check(rsp_data === exp, {tag, " data"}, rsp_data, exp);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        check(rsp_valid === 1'b0, {tag, " empty"}, {7'd0, rsp_valid}, 8'h00);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_empty("R1 after reset");

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            send(VECS[i].en, VECS[i].dis, VECS[i].cmd);
            if (VECS[i].drain) begin
                if (VECS[i].n > 2'd0) pop_expect(VECS[i].b0, tag);
                if (VECS[i].n > 2'd1) pop_expect(VECS[i].b1, tag);
                if (VECS[i].n > 2'd2) pop_expect(VECS[i].b2, tag);
                expect_empty(tag);
            end
        end

        // R8: stall holds head byte steady
        send(1'b1, 1'b0, 8'h01);
        for (int k = 0; k < 3; k++) begin
            check(rsp_valid === 1'b1 && rsp_data === 8'hFF, "R8 stall hold", rsp_data, 8'hFF);
            @(negedge clk);
        end
        // R2: response sent on top of a partly drained one replaces it
        pop_expect(8'hFF, "R8 first pop");
        send(1'b1, 1'b0, 8'h01);
        pop_expect(8'hFF, "R2 refill");
        pop_expect(8'h04, "R2 refill");
        pop_expect(8'h7F, "R2 refill");
        expect_empty("R2 refill");

        // R1: reset empties a loaded queue and clears LED mode
        send(1'b1, 1'b0, 8'h0F);
        send(1'b1, 1'b0, 8'h0E);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_empty("R1 reset mid-queue");
        send(1'b1, 1'b0, 8'h07);
        pop_expect(8'hFE, "R1 LED mode cleared");
        pop_expect(8'h00, "R1 LED mode cleared");
        expect_empty("R1 LED mode cleared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule